// File: doc/BRIEF.md
# Supply Window Power-Good Monitor

This block judges whether a set of supply rails is healthy. A 5-bit voltage-identification code selects the core-rail target in millivolts through a two-segment map. A digitized core sample is then compared against percentage windows of that target. Each window threshold has a separate rising and falling level, which gives hysteresis. Three auxiliary rail samples are each checked against an undervoltage level set as a fraction of a per-rail nominal value. The block drives a single power-good output, a core overvoltage flag, and the decoded target.

The block sits behind the converters' sampling logic. A fault supervisor elsewhere consumes `ov_trip` and decides whether to latch it; this block latches nothing. Power-good also needs a soft-start-done indication. It is held low for a programmable number of cycles after the identification code changes, so that a window built on a stale target cannot report good. One reserved code turns the rail off: power-good stays low and no overvoltage is flagged. All thresholds are worked out in integer millivolts and rounded toward the safe side: lower limits are rounded up and upper limits are rounded down.

Top module: `pg_window_monitor`

## Requirements
- R1: When vid[4] is 0, vref_mv becomes 1300 + 50*(15 - vid[3:0]) mV one clock edge after the code is applied.
- R2: When vid[4] is 1 and vid is not 5'b11111, vref_mv becomes 2100 + 100*(14 - vid[3:0]) mV one edge later. Code 5'b11111 gives vref_mv = 0.
- R3: While the captured code is 5'b11111, power_good and ov_trip are both 0, whatever the rail samples are.
- R4: Lower core limit. The core-low-ok state sets when core_mv >= ceil(94% of the target). Once set, it clears only when core_mv < ceil(92% of the target).
- R5: Upper core limit. The core-high-fault state sets when core_mv > floor(110% of the target). Once set, it clears only when core_mv <= floor(108% of the target).
- R6: ov_trip is 1 exactly when, at the previous edge, core_mv > floor(115% of the target) and the code was not 5'b11111. It does not depend on the settle count or on soft-start.
- R7: Each auxiliary rail i has its sample in aux_mv[13*i +: 13], with nominal 1500, 1800 and 3300 mV for i = 0, 1, 2. Its ok state sets when the sample >= ceil(75% of nominal) and clears when the sample < ceil(68% of nominal).
- R8: power_good is the AND of six terms: core-low-ok, no core-high-fault, all auxiliary rails ok, ss_done sampled at the previous edge, a settle count of zero, and a captured code other than 5'b11111.
- R9: When an edge captures a code different from the stored one, power_good stays 0 for SETTLE_CYCLES (default 8) cycles after that edge. The same hold applies after reset.
- R10: During reset, power_good = 0, ov_trip = 0 and vref_mv = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid | input | 5 | Voltage-identification code |
| core_mv | input | 13 | Core rail sample in mV |
| aux_mv | input | 39 | Three auxiliary rail samples, 13 bits each |
| ss_done | input | 1 | Soft-start complete |
| power_good | output | 1 | All rails within limits |
| ov_trip | output | 1 | Core above the overvoltage limit |
| vref_mv | output | 13 | Decoded core target in mV |

## Verification
Every decision in this block lives in a few state bits: two core hysteresis flags, three auxiliary flags and a settle counter. A wrong state bit reaches power_good in the cycle after the edge that set it. It appears as a one-cycle mismatch at a threshold crossing, or as power_good rising one or more cycles early or late after a code change. A decode error shows at once on vref_mv, and it skews ov_trip against the sample.

The bench runs a cycle-accurate model built from the requirements and compares all three outputs after every edge. It walks each threshold from both sides, one millivolt at a time, to expose off-by-one rounding and hysteresis mistakes.

// File: rtl/pg_window_monitor.sv
module pg_window_monitor #(
  parameter int MV_W          = 13,
  parameter int N_AUX         = 3,
  parameter int SETTLE_CYCLES = 8,
  parameter logic [N_AUX*16-1:0] AUX_NOM_MV = {16'd3300, 16'd1800, 16'd1500},
  parameter int PG_LO_ON      = 94,
  parameter int PG_LO_OFF     = 92,
  parameter int PG_HI_ON      = 110,
  parameter int PG_HI_OFF     = 108,
  parameter int OV_PCT        = 115,
  parameter int AUX_ON_PCT    = 75,
  parameter int AUX_OFF_PCT   = 68
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             vid,
  input  logic [MV_W-1:0]        core_mv,
  input  logic [N_AUX*MV_W-1:0]  aux_mv,
  input  logic                   ss_done,
  output logic                   power_good,
  output logic                   ov_trip,
  output logic [MV_W-1:0]        vref_mv
);

  localparam int         CNT_W   = $clog2(SETTLE_CYCLES + 1);
  localparam logic [4:0] VID_OFF = 5'h1F;

  function automatic logic [MV_W-1:0] decode_vid(input logic [4:0] c);
    int mv;
    if (c == VID_OFF)  mv = 0;
    else if (!c[4])    mv = 1300 + 50 * (15 - int'(c[3:0]));
    else               mv = 2100 + 100 * (14 - int'(c[3:0]));
    return MV_W'(mv);
  endfunction

  function automatic logic [MV_W-1:0] pct_of(input int base, input int pct, input logic up);
    int prod;
    prod = base * pct + (up ? 99 : 0);
    return MV_W'(prod / 100);
  endfunction

  logic [MV_W-1:0]  ref_now;
  logic [MV_W-1:0]  lo_on_th, lo_off_th, hi_on_th, hi_off_th, ov_th;
  logic [4:0]       vid_q;
  logic [CNT_W-1:0] settle_cnt;
  logic             lo_ok, hi_bad, ss_q;
  logic [N_AUX-1:0] aux_ok;

  assign ref_now   = decode_vid(vid);
  assign lo_on_th  = pct_of(int'(ref_now), PG_LO_ON,  1'b1);
  assign lo_off_th = pct_of(int'(ref_now), PG_LO_OFF, 1'b1);
  assign hi_on_th  = pct_of(int'(ref_now), PG_HI_ON,  1'b0);
  assign hi_off_th = pct_of(int'(ref_now), PG_HI_OFF, 1'b0);
  assign ov_th     = pct_of(int'(ref_now), OV_PCT,    1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q      <= '0;
      vref_mv    <= '0;
      ss_q       <= 1'b0;
      settle_cnt <= CNT_W'(SETTLE_CYCLES);
      lo_ok      <= 1'b0;
      hi_bad     <= 1'b0;
      ov_trip    <= 1'b0;
    end else begin
      vid_q   <= vid;
      vref_mv <= ref_now;
      ss_q    <= ss_done;
      if (vid != vid_q)        settle_cnt <= CNT_W'(SETTLE_CYCLES);
      else if (settle_cnt != 0) settle_cnt <= settle_cnt - 1'b1;
      lo_ok   <= lo_ok  ? (core_mv >= lo_off_th) : (core_mv >= lo_on_th);
      hi_bad  <= hi_bad ? (core_mv >  hi_off_th) : (core_mv >  hi_on_th);
      ov_trip <= (vid != VID_OFF) && (core_mv > ov_th);
    end
  end

  for (genvar i = 0; i < N_AUX; i++) begin : g_aux
    logic [MV_W-1:0] smp, on_th, off_th;
    assign smp    = aux_mv[i*MV_W +: MV_W];
    assign on_th  = pct_of(int'(AUX_NOM_MV[i*16 +: 16]), AUX_ON_PCT,  1'b1);
    assign off_th = pct_of(int'(AUX_NOM_MV[i*16 +: 16]), AUX_OFF_PCT, 1'b1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aux_ok[i] <= 1'b0;
      else        aux_ok[i] <= aux_ok[i] ? (smp >= off_th) : (smp >= on_th);
    end
  end

  assign power_good = lo_ok & ~hi_bad & (&aux_ok) & ss_q &
                      (settle_cnt == '0) & (vid_q != VID_OFF);

endmodule

// File: rtl/pg_window_monitor_chk.sv
module pg_window_monitor_chk #(
  parameter int MV_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      vid,
  input logic [4:0]      vid_q,
  input logic            ss_done,
  input logic            power_good,
  input logic            ov_trip,
  input logic [MV_W-1:0] vref_mv
);

  logic up;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  AST_PG_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    up && !$past(ss_done) |-> !power_good); // R8

  AST_OFF_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (vref_mv == '0) |-> (!power_good && !ov_trip)); // R3

  AST_VID_CHANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vid != vid_q) |=> !power_good); // R9

  AST_PG_EXCLUDES_OV: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> !ov_trip); // R6

  AST_VREF_SEGMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (vref_mv == '0) || (vref_mv >= MV_W'(1300) && vref_mv <= MV_W'(3500))); // R2

endmodule

bind pg_window_monitor pg_window_monitor_chk #(.MV_W(MV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vid(vid), .vid_q(vid_q), .ss_done(ss_done),
  .power_good(power_good), .ov_trip(ov_trip), .vref_mv(vref_mv));

// File: tb/pg_window_monitor_tb.sv
`timescale 1ns/1ps
module pg_window_monitor_tb_top;
  localparam int MV_W = 13;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] vid = '0;
  logic [MV_W-1:0] core = '0;
  logic [3*MV_W-1:0] aux = '0;
  logic ss = 1'b0;
  logic pg, ov;
  logic [MV_W-1:0] vref;

  int n_tests = 0, n_fail = 0;
  const int NOM[3] = '{1500, 1800, 3300};

  bit m_lo, m_hi, m_ov, m_ss;
  bit [2:0] m_aux;
  int m_cnt, m_vref;
  logic [4:0] m_vidq;

  always #10 clk = ~clk;

  pg_window_monitor #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid(vid), .core_mv(core), .aux_mv(aux),
    .ss_done(ss), .power_good(pg), .ov_trip(ov), .vref_mv(vref));

  function automatic int f_ref(input logic [4:0] c);
    if (c == 5'h1F) return 0;
    if (c[4] == 1'b0) return 1300 + 50 * (15 - int'(c[3:0]));
    return 2100 + 100 * (14 - int'(c[3:0]));
  endfunction

  function automatic int f_ceil(input int b, input int p);
    return (b * p + 99) / 100;
  endfunction

  function automatic int f_floor(input int b, input int p);
    return (b * p) / 100;
  endfunction

  task automatic model_edge();
    int r, c, s;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_ov = 0; m_ss = 0; m_aux = '0;
      m_cnt = SETTLE; m_vidq = '0; m_vref = 0;
    end else begin
      r = f_ref(vid); c = int'(core);
      if (vid != m_vidq) m_cnt = SETTLE; else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_lo = m_lo ? (c >= f_ceil(r, 92)) : (c >= f_ceil(r, 94));
      m_hi = m_hi ? (c > f_floor(r, 108)) : (c > f_floor(r, 110));
      m_ov = (vid != 5'h1F) && (c > f_floor(r, 115));
      for (int i = 0; i < 3; i++) begin
        s = int'(aux[i*MV_W +: MV_W]);
        m_aux[i] = m_aux[i] ? (s >= f_ceil(NOM[i], 68)) : (s >= f_ceil(NOM[i], 75));
      end
      m_ss = ss; m_vidq = vid; m_vref = r;
    end
  endtask

  task automatic check(input string tag);
    bit e_pg;
    e_pg = m_lo && !m_hi && (&m_aux) && m_ss && (m_cnt == 0) && (m_vidq != 5'h1F);
    n_tests += 3;
    if (int'(vref) != m_vref) begin
      n_fail++; $display("FAIL %s vref_mv actual=%0d expected=%0d", tag, vref, m_vref);
    end
    if (pg !== e_pg) begin
      n_fail++; $display("FAIL %s power_good actual=%0b expected=%0b", tag, pg, e_pg);
    end
    if (ov !== m_ov) begin
      n_fail++; $display("FAIL %s ov_trip actual=%0b expected=%0b", tag, ov, m_ov);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk); model_edge();
    @(negedge clk); check(tag);
  endtask

  task automatic set_aux_nominal();
    for (int i = 0; i < 3; i++) aux[i*MV_W +: MV_W] = MV_W'(NOM[i]);
  endtask

  task automatic core_seq(input string tag, input int v);
    core = MV_W'(v); cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    repeat (3) cyc("R10");
    rst_n = 1'b1;

    vid = 5'b00001; ss = 1'b1; core = MV_W'(2000); set_aux_nominal();
    repeat (SETTLE + 2) cyc("R9");

    core_seq("R4", 1879); core_seq("R4", 1880); core_seq("R4", 1850);
    core_seq("R4", 1840); core_seq("R4", 1839); core_seq("R4", 1870);
    core_seq("R4", 1880); core_seq("R4", 2000);

    core_seq("R5", 2200); core_seq("R5", 2201); core_seq("R5", 2180);
    core_seq("R5", 2161); core_seq("R5", 2160); core_seq("R5", 2000);

    core_seq("R6", 2300); core_seq("R6", 2301); core_seq("R6", 2299);
    core_seq("R6", 2000);

    aux[1*MV_W +: MV_W] = MV_W'(1223); cyc("R7");
    aux[1*MV_W +: MV_W] = MV_W'(1300); cyc("R7");
    aux[1*MV_W +: MV_W] = MV_W'(1349); cyc("R7");
    aux[1*MV_W +: MV_W] = MV_W'(1350); cyc("R7");
    aux[1*MV_W +: MV_W] = MV_W'(1224); cyc("R7");
    aux[1*MV_W +: MV_W] = MV_W'(1223); cyc("R7");
    set_aux_nominal(); cyc("R7");

    ss = 1'b0; cyc("R8"); ss = 1'b1; cyc("R8"); cyc("R8");

    vid = 5'b10000; core = MV_W'(3500);
    repeat (3) cyc("R9");
    vid = 5'b00001; core = MV_W'(2000); cyc("R9");
    repeat (SETTLE + 1) cyc("R9");

    vid = 5'h1F; core = MV_W'(2000);
    repeat (SETTLE + 2) cyc("R3");
    core = MV_W'(4000); cyc("R3"); cyc("R3");

    for (int c = 0; c < 32; c++) begin
      vid = 5'(c);
      cyc(c >= 16 ? "R2" : "R1");
    end

    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 40 == 0) vid = 5'($urandom);
      r = f_ref(vid);
      if (r == 0) r = 2000;
      core = MV_W'(r * (84 + int'($urandom % 34)) / 100);
      for (int i = 0; i < 3; i++)
        if ($urandom % 8 == 0)
          aux[i*MV_W +: MV_W] = MV_W'(NOM[i] * (62 + int'($urandom % 45)) / 100);
      ss = ($urandom % 20) != 0;
      cyc("R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule